// File: doc/BRIEF.md
# Word-Copy DMA Engine with Byte Reversal

This block moves a run of 32-bit words from one memory address to another over a single master port. A host sets it up through a small register window that takes both byte and word writes. Writing the word count starts the copy. While the copy runs, the engine reads one word, writes it out, steps both addresses by four bytes and counts the run down. If the swap bit in the configuration byte is set, the engine reverses the byte order of each word before writing it.

When the run ends, a pending flag is set and the interrupt output rises. Both stay set until the host writes an acknowledge. A side command register loads a result register with one of two words. The first is a fixed identification word. The second is a timing status word, derived from a flag that a frame-start input sets and a status-change pulse clears.

Top module: `wordcopy_dma`

## Requirements
- R1: Word writes (access width 1) set the source address at offset 0x00, the destination address at 0x04 and the word count at 0x08. A nonzero count write starts the copy, and the first read request goes out at the source address on the next cycle.
- R2: Each word is read from the current source and then written to the current destination, with only one request outstanding. A request holds its address and type until ready. Both addresses then advance by 4, and the copy stops after exactly the programmed number of words.
- R3: A count of zero starts no memory access and sets the pending flag on the clock edge that takes the write.
- R4: When a copy completes, bit 0 of the status byte (byte read at 0x0C) and the `irq` output are set, and both stay set until acknowledged.
- R5: A byte write to 0x0D with data bit 0 set clears the pending bit and `irq`. The same write with bit 0 clear has no effect.
- R6: The configuration byte at 0x0E can be written and read back. With its bit 7 set, each copied word is written with byte 0 swapped with byte 3 and byte 1 swapped with byte 2.
- R7: Status bit 7 is 1 from the start of a copy until its last word is written. While it is 1, every register write other than the acknowledge is ignored.
- R8: A word write to the command register 0x10 with bit 29 set loads the result register (word read at 0x14) with the identification word, default 0x16C311DB.
- R9: A command write with bit 31 set and bit 29 clear loads the result with 0xFFFFFFFF if the timing flag is set, and with 0x00000000 if it is clear. `frameStart` sets the flag and `statusPulse` clears it; the pulse wins when both arrive together. The flag is clear after reset. A command write with neither bit set leaves the result unchanged.
- R10: A word write to 0x14 sets the result to 0xFFFFFFFF.
- R11: After reset the status, configuration and result read as zero, `irq` is 0 and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostWide | input | 1 | Access width: 1 = word, 0 = byte (data in bits 7:0) |
| hostAddr | input | 5 | Register byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Read data for hostAddr (combinational) |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Request type: 1 = write, 0 = read |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Write data, swapped if enabled |
| memReady | input | 1 | Memory accepts the request; read data valid |
| memRdata | input | 32 | Read data |
| frameStart | input | 1 | Sets the timing flag |
| statusPulse | input | 1 | Clears the timing flag |
| irq | output | 1 | Copy-done interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- a read handshake is always followed by a write request;
- a stalled request keeps its address and type;
- addresses step by four and the count steps by one per word;
- the interrupt holds until acknowledged;
- the configuration stays frozen while busy.

Other behaviour only the bench scenarios can show. These are the copied data with and without byte reversal, the exact word counts and the zero-length case. They also cover the identification and timing results for each flag history and the writes that are ignored during a copy.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

  typedef struct packed {
    logic loadSrc;
    logic loadDst;
    logic loadLen;
    logic capture;
    logic advance;
    logic swapEn;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } copyState_t;

  localparam logic [4:0] OFF_SRC  = 5'h00;
  localparam logic [4:0] OFF_DST  = 5'h04;
  localparam logic [4:0] OFF_LEN  = 5'h08;
  localparam logic [4:0] OFF_STAT = 5'h0C;
  localparam logic [4:0] OFF_ACK  = 5'h0D;
  localparam logic [4:0] OFF_CFG  = 5'h0E;
  localparam logic [4:0] OFF_CMD  = 5'h10;
  localparam logic [4:0] OFF_RES  = 5'h14;

  localparam int CMD_ID_BIT   = 29;
  localparam int CMD_TIME_BIT = 31;
  localparam int CFG_SWAP_BIT = 7;

endpackage

// File: rtl/dmaw_datapath.sv
module dmaw_datapath
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] wordOut,
  output logic              lenIsOne
);

  localparam int BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);
  localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

  logic [LEN_W-1:0]  lenLeft;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] swapped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      lenLeft <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.loadSrc) srcAddr <= wrData[ADDR_W-1:0];
      if (strobe.loadDst) dstAddr <= wrData[ADDR_W-1:0];
      if (strobe.loadLen) lenLeft <= wrData[LEN_W-1:0];
      if (strobe.capture) dataReg <= memRdata;
      if (strobe.advance) begin
        srcAddr <= srcAddr + STEP;
        dstAddr <= dstAddr + STEP;
        lenLeft <= lenLeft - ONE;
      end
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = dataReg[8*(BYTES-1-b) +: 8];
  end

  assign wordOut  = strobe.swapEn ? swapped : dataReg;
  assign lenIsOne = (lenLeft == ONE);

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> srcAddr == $past(srcAddr) + STEP); // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> dstAddr == $past(dstAddr) + STEP); // R2
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> lenLeft == $past(lenLeft) - ONE); // R2

endmodule

// File: rtl/dmaw_ctrl.sv
module dmaw_ctrl
  import dmaw_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          LEN_W   = 32,
  parameter logic [31:0] ID_WORD = 32'h16C311DB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostWide,
  input  logic [4:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              memReady,
  input  logic              frameStart,
  input  logic              statusPulse,
  input  logic              lenIsOne,
  output dpStrobe_t         strobe,
  output logic              memValid,
  output logic              memWrite,
  output logic              irq
);

  copyState_t state, stateNext;
  logic       pending;
  logic [7:0] cfg;
  logic       timeFlag;
  logic [DATA_W-1:0] result;

  logic busy, accept, wordWr, byteWr;
  logic writeSrc, writeDst, writeLen, writeCfg, writeCmd, writeRes;
  logic ackHit, zeroStart, finish;

  assign busy   = (state != ST_IDLE);
  assign accept = !busy;
  assign wordWr = hostWe && hostWide;
  assign byteWr = hostWe && !hostWide;

  assign writeSrc = accept && wordWr && hostAddr == OFF_SRC;
  assign writeDst = accept && wordWr && hostAddr == OFF_DST;
  assign writeLen = accept && wordWr && hostAddr == OFF_LEN;
  assign writeCmd = accept && wordWr && hostAddr == OFF_CMD;
  assign writeRes = accept && wordWr && hostAddr == OFF_RES;
  assign writeCfg = accept && byteWr && hostAddr == OFF_CFG;
  assign ackHit   = byteWr && hostAddr == OFF_ACK && hostWdata[0];

  assign zeroStart = writeLen && (hostWdata[LEN_W-1:0] == '0);

  always_comb begin
    strobe         = '0;
    strobe.loadSrc = writeSrc;
    strobe.loadDst = writeDst;
    strobe.loadLen = writeLen;
    strobe.capture = (state == ST_READ) && memReady;
    strobe.advance = (state == ST_WRITE) && memReady;
    strobe.swapEn  = cfg[CFG_SWAP_BIT];
  end

  assign finish = zeroStart || (strobe.advance && lenIsOne);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (writeLen && !zeroStart) stateNext = ST_READ;
      ST_READ:  if (memReady) stateNext = ST_WRITE;
      ST_WRITE: if (memReady) stateNext = lenIsOne ? ST_IDLE : ST_READ;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pending  <= 1'b0;
      cfg      <= '0;
      timeFlag <= 1'b0;
      result   <= '0;
    end else begin
      state <= stateNext;
      if (finish)      pending <= 1'b1;
      else if (ackHit) pending <= 1'b0;
      if (writeCfg) cfg <= hostWdata[7:0];
      if (statusPulse)     timeFlag <= 1'b0;
      else if (frameStart) timeFlag <= 1'b1;
      if (writeCmd) begin
        if (hostWdata[CMD_ID_BIT])        result <= DATA_W'(ID_WORD);
        else if (hostWdata[CMD_TIME_BIT]) result <= timeFlag ? '1 : '0;
      end else if (writeRes) begin
        result <= '1;
      end
    end
  end

  always_comb begin
    case (hostAddr)
      OFF_STAT: hostRdata = DATA_W'({busy, 6'b0, pending});
      OFF_CFG:  hostRdata = DATA_W'(cfg);
      OFF_RES:  hostRdata = result;
      default:  hostRdata = '0;
    endcase
  end

  assign memValid = busy;
  assign memWrite = (state == ST_WRITE);
  assign irq      = pending;

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && memReady) |=> (memValid && memWrite)); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite))); // R2
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ackHit) |=> irq); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackHit && !finish) |=> !irq); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg)); // R7

endmodule

// File: rtl/wordcopy_dma.sv
module wordcopy_dma
  import dmaw_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          LEN_W   = 32,
  parameter logic [31:0] ID_WORD = 32'h16C311DB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic              hostWide,
  input  logic [4:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              frameStart,
  input  logic              statusPulse,
  output logic              irq
);

  dpStrobe_t strobe;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic lenIsOne;

  dmaw_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ID_WORD(ID_WORD)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWe(hostWe), .hostWide(hostWide), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memReady(memReady), .frameStart(frameStart), .statusPulse(statusPulse),
    .lenIsOne(lenIsOne), .strobe(strobe),
    .memValid(memValid), .memWrite(memWrite), .irq(irq)
  );

  dmaw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(hostWdata), .memRdata(memRdata),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .wordOut(memWdata), .lenIsOne(lenIsOne)
  );

  assign memAddr = memWrite ? dstAddr : srcAddr;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> $stable(memAddr)); // R2

endmodule

// File: tb/test_wordcopy_dma.sv
module test_wordcopy_dma;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0, hostWide = 1'b0;
  logic [4:0] hostAddr = '0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic memValid, memWrite, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic frameStart = 1'b0, statusPulse = 1'b0, irq;

  always #10 clk = ~clk;

  wordcopy_dma i_wordcopy_dma (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostWide(hostWide),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .frameStart(frameStart), .statusPulse(statusPulse), .irq(irq)
  );

  int errors = 0, checks = 0;
  int rdCnt = 0, wrCnt = 0, orderErr = 0;
  logic readOpen = 1'b0;
  logic stall = 1'b0, readyTog = 1'b0;
  logic [31:0] mem [0:255];

  function automatic logic [31:0] pat(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'hA5, b, 8'h3C, ~b};
  endfunction

  function automatic logic [31:0] bswap(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign memReady = stall ? readyTog : 1'b1;
  assign memRdata = mem[memAddr[9:2]];

  always @(negedge clk) readyTog <= ~readyTog;

  always @(posedge clk) begin
    if (memValid && memReady) begin
      if (memWrite) begin
        mem[memAddr[9:2]] <= memWdata;
        wrCnt <= wrCnt + 1;
        if (!readOpen) orderErr <= orderErr + 1;
        readOpen <= 1'b0;
      end else begin
        rdCnt <= rdCnt + 1;
        if (readOpen) orderErr <= orderErr + 1;
        readOpen <= 1'b1;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [4:0] a, logic wide, logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostWide = wide; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic readReg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic waitIrq();
    for (int n = 0; n < 3000 && !irq; n++) @(negedge clk);
  endtask

  // fields: [24] swap, [23:16] words, [15:8] dst word, [7:0] src word
  localparam logic [24:0] COPY_TAB [4] = '{
    {1'b0, 8'd4,  8'd64,  8'd0},
    {1'b1, 8'd7,  8'd100, 8'd10},
    {1'b0, 8'd1,  8'd32,  8'd200},
    {1'b1, 8'd16, 8'd160, 8'd128}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r, exp;
    int w0, r0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    readReg(5'h0C, r); chk(r == 0, "R11 status", r, 0);
    readReg(5'h0E, r); chk(r == 0, "R11 cfg", r, 0);
    readReg(5'h14, r); chk(r == 0, "R11 result", r, 0);
    chk(!irq && !memValid, "R11 irq/memValid", {30'd0, irq, memValid}, 0);

    // table-driven copies: R1 R2 R4 R5 R6
    for (int k = 0; k < 4; k++) begin
      int s = int'(COPY_TAB[k][7:0]);
      int d = int'(COPY_TAB[k][15:8]);
      int n = int'(COPY_TAB[k][23:16]);
      logic sw = COPY_TAB[k][24];
      stall = (k % 2 == 1);
      writeReg(5'h0E, 1'b0, sw ? 32'h80 : 32'h00);
      writeReg(5'h00, 1'b1, 32'(s * 4));
      writeReg(5'h04, 1'b1, 32'(d * 4));
      w0 = wrCnt;
      writeReg(5'h08, 1'b1, 32'(n));
      chk(memValid && !memWrite && memAddr == 32'(s * 4), "R1 first read",
          memAddr, 32'(s * 4));
      waitIrq();
      chk(irq == 1'b1, "R4 irq", {31'd0, irq}, 1);
      for (int i = 0; i < n; i++) begin
        exp = sw ? bswap(pat(s + i)) : pat(s + i);
        chk(mem[d + i] == exp, sw ? "R6 swapped word" : "R2 copied word",
            mem[d + i], exp);
      end
      chk(wrCnt - w0 == n, "R2 word count", 32'(wrCnt - w0), 32'(n));
      readReg(5'h0C, r); chk(r == 32'h01, "R4 status pending", r, 32'h01);
      writeReg(5'h0D, 1'b0, 32'h01);
      readReg(5'h0C, r); chk(r == 0 && !irq, "R5 ack clears", r, 0);
    end
    stall = 1'b0;
    chk(orderErr == 0, "R2 read/write order", 32'(orderErr), 0);

    // R6 config readback
    writeReg(5'h0E, 1'b0, 32'h5A);
    readReg(5'h0E, r); chk(r == 32'h5A, "R6 cfg readback", r, 32'h5A);
    writeReg(5'h0E, 1'b0, 32'h80);
    readReg(5'h0E, r); chk(r == 32'h80, "R6 cfg readback", r, 32'h80);

    // R7 busy and ignored writes
    writeReg(5'h14, 1'b1, 32'h0);
    readReg(5'h14, r); chk(r == 32'hFFFFFFFF, "R10 result forced", r, 32'hFFFFFFFF);
    stall = 1'b1;
    writeReg(5'h00, 1'b1, 32'd4 * 20);
    writeReg(5'h04, 1'b1, 32'd4 * 220);
    writeReg(5'h08, 1'b1, 32'd8);
    readReg(5'h0C, r); chk(r[7] == 1'b1, "R7 busy bit", r, 32'h80);
    writeReg(5'h0E, 1'b0, 32'h00);
    writeReg(5'h10, 1'b1, 32'h20000000);
    writeReg(5'h00, 1'b1, 32'd0);
    readReg(5'h0E, r); chk(r == 32'h80, "R7 cfg ignored", r, 32'h80);
    readReg(5'h14, r); chk(r == 32'hFFFFFFFF, "R7 cmd ignored", r, 32'hFFFFFFFF);
    waitIrq();
    stall = 1'b0;
    readReg(5'h0C, r); chk(r == 32'h01, "R7 busy drops", r, 32'h01);
    chk(mem[227] == bswap(pat(27)), "R7 src kept", mem[227], bswap(pat(27)));

    // R5 ack with bit0 clear ignored
    writeReg(5'h0D, 1'b0, 32'hFE);
    chk(irq == 1'b1, "R5 ack bit0 clear ignored", {31'd0, irq}, 1);
    writeReg(5'h0D, 1'b0, 32'h01);
    chk(irq == 1'b0, "R5 ack", {31'd0, irq}, 0);

    // R3 zero length
    w0 = wrCnt; r0 = rdCnt;
    writeReg(5'h08, 1'b1, 32'd0);
    chk(irq == 1'b1, "R3 zero-length irq", {31'd0, irq}, 1);
    repeat (4) @(negedge clk);
    chk(wrCnt == w0 && rdCnt == r0 && !memValid, "R3 no access",
        32'(wrCnt - w0 + rdCnt - r0), 0);
    writeReg(5'h0D, 1'b0, 32'h01);

    // R8 identification
    writeReg(5'h10, 1'b1, 32'h20000000);
    readReg(5'h14, r); chk(r == 32'h16C311DB, "R8 id word", r, 32'h16C311DB);
    writeReg(5'h14, 1'b1, 32'h0);
    writeReg(5'h10, 1'b1, 32'hA0000000);
    readReg(5'h14, r); chk(r == 32'h16C311DB, "R8 id wins over timing", r, 32'h16C311DB);

    // R9 timing flag
    writeReg(5'h10, 1'b1, 32'h80000000);
    readReg(5'h14, r); chk(r == 0, "R9 flag clear after reset", r, 0);
    @(negedge clk); frameStart = 1'b1; @(negedge clk); frameStart = 1'b0;
    writeReg(5'h10, 1'b1, 32'h80000000);
    readReg(5'h14, r); chk(r == 32'hFFFFFFFF, "R9 flag set", r, 32'hFFFFFFFF);
    writeReg(5'h10, 1'b1, 32'h00000001);
    readReg(5'h14, r); chk(r == 32'hFFFFFFFF, "R9 no-op command", r, 32'hFFFFFFFF);
    @(negedge clk); statusPulse = 1'b1; @(negedge clk); statusPulse = 1'b0;
    writeReg(5'h10, 1'b1, 32'h80000000);
    readReg(5'h14, r); chk(r == 0, "R9 flag cleared", r, 0);
    @(negedge clk); frameStart = 1'b1; statusPulse = 1'b1;
    @(negedge clk); frameStart = 1'b0; statusPulse = 1'b0;
    writeReg(5'h10, 1'b1, 32'h80000000);
    readReg(5'h14, r); chk(r == 0, "R9 pulse wins", r, 0);

    // R10 again from zero
    writeReg(5'h14, 1'b1, 32'h12345678);
    readReg(5'h14, r); chk(r == 32'hFFFFFFFF, "R10 result forced", r, 32'hFFFFFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule